// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block fetches a missing address translation from memory without a software miss handler. A caller supplies a 20-bit virtual page number and the physical base address of the top-level table. The walker reads one 32-bit directory entry, then one 32-bit leaf entry, over a single-request memory read port whose response may arrive any number of cycles later. It then pulses `done` with either the physical frame number and the permission bits of the mapping, or a page-fault flag that tells which level held the invalid entry.

The high ten bits of the page number select the directory slot. The low ten bits select the slot in the second-level table. Only one walk runs at a time. `busy` tells the caller when a new request will be taken. The walker produces the entry that a translation cache would install, and nothing more.

Top module: `page_walker`

## Requirements
- R1: After reset `busy`, `done`, `memReq` and `fault` are all low.
- R2: A `walkReq` seen while `busy` is low is accepted. In the next cycle `busy` is high and `memReq` is high with `memAddr` = `tableBase` + 4 × `walkVpn[19:10]`.
- R3: When the directory response has bit 0 = 1, the cycle after that response carries `memReq` with `memAddr` = {response[31:12], 12'b0} + 4 × `walkVpn[9:0]`.
- R4: When the leaf response has bit 0 = 1, `done` is high in the cycle after that response. In that cycle `fault` = 0, `resultPpn` = response[31:12], `resultWritable` = response bit 1 and `resultUser` = response bit 2.
- R5: When the directory response has bit 0 = 0, `done` is high in the next cycle with `fault` = 1 and `faultLevel` = 0, and no second read is issued.
- R6: When the leaf response has bit 0 = 0, `done` is high in the next cycle with `fault` = 1 and `faultLevel` = 1.
- R7: `busy` stays high from the cycle after acceptance through the `done` cycle and is low in the cycle after `done`. While it is high, `walkReq`, `walkVpn` and `tableBase` have no effect on the addresses or the result.
- R8: `memValid` has no effect unless the walker is waiting for a response it has requested. A stray pulse while idle, or in a request cycle, produces no `done` and no `busy`.
- R9: `memReq` is a single-cycle pulse for each level. It is high only while `busy` is high. Any response latency of one cycle or more after the request is accepted.
- R10: `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| walkReq | input | 1 | Start a walk (taken only while not busy) |
| walkVpn | input | 20 | Virtual page number to translate |
| tableBase | input | 32 | Physical byte address of the directory |
| busy | output | 1 | A walk is in progress |
| memReq | output | 1 | Read request strobe |
| memAddr | output | 32 | Read byte address |
| memValid | input | 1 | Read data valid |
| memData | input | 32 | Read data (entry) |
| done | output | 1 | Result valid this cycle |
| resultPpn | output | 20 | Physical frame number of the mapping |
| resultWritable | output | 1 | Mapping allows writes |
| resultUser | output | 1 | Mapping allows user access |
| fault | output | 1 | Walk ended on an invalid entry |
| faultLevel | output | 1 | 0 = directory invalid, 1 = leaf invalid |

## Verification
The properties assume that the memory side returns at most one `memValid` pulse for each request, and never in the same cycle as the request. They also assume that `walkReq` only matters while `busy` is low. The stimulus is built so that these assumptions hold. Its responder counts down a latency of at least one cycle from each observed request, while request pulses are issued during walks and stray valid pulses only when idle. The reference model tracks the expected busy, request, address and result on every cycle from its own memory image, so that both faulting levels and both permission bits are reached.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int PA_BITS_DEF     = 32;
  localparam int OFFSET_BITS_DEF = 12;
  localparam int LEVEL_BITS_DEF  = 10;
  localparam int ENTRY_SHIFT     = 2;   // 4-byte entries
  localparam int VALID_BIT       = 0;
  localparam int WRITE_BIT       = 1;
  localparam int USER_BIT        = 2;

  typedef enum logic [2:0] {
    PW_IDLE, PW_READ_DIR, PW_WAIT_DIR, PW_READ_PTE, PW_WAIT_PTE, PW_DONE
  } walkState_t;

  typedef struct packed {
    logic latchReq;   // capture request operands
    logic issueDir;   // drive directory address
    logic takeDir;    // consume directory response
    logic issuePte;   // drive leaf address
    logic takePte;    // consume leaf response
  } walkStrobes_t;
endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         walkReq,
  input  logic         memValid,
  input  logic         entryValid,
  output walkStrobes_t strobes,
  output logic         busy,
  output logic         memReq,
  output logic         done
);
  walkState_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= PW_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD  = stateQ;
    strobes = '0;
    unique case (stateQ)
      PW_IDLE: if (walkReq) begin
        strobes.latchReq = 1'b1;
        stateD = PW_READ_DIR;
      end
      PW_READ_DIR: begin
        strobes.issueDir = 1'b1;
        stateD = PW_WAIT_DIR;
      end
      PW_WAIT_DIR: if (memValid) begin
        strobes.takeDir = 1'b1;
        stateD = entryValid ? PW_READ_PTE : PW_DONE;
      end
      PW_READ_PTE: begin
        strobes.issuePte = 1'b1;
        stateD = PW_WAIT_PTE;
      end
      PW_WAIT_PTE: if (memValid) begin
        strobes.takePte = 1'b1;
        stateD = PW_DONE;
      end
      PW_DONE: stateD = PW_IDLE;
      default: stateD = PW_IDLE;
    endcase
  end

  assign busy   = (stateQ != PW_IDLE);
  assign done   = (stateQ == PW_DONE);
  assign memReq = strobes.issueDir | strobes.issuePte;
endmodule

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int PA_BITS     = PA_BITS_DEF,
  parameter int OFFSET_BITS = OFFSET_BITS_DEF,
  parameter int LEVEL_BITS  = LEVEL_BITS_DEF,
  localparam int VPN_BITS   = 2 * LEVEL_BITS,
  localparam int FRAME_BITS = PA_BITS - OFFSET_BITS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  walkStrobes_t          strobes,
  input  logic [VPN_BITS-1:0]   walkVpn,
  input  logic [PA_BITS-1:0]    tableBase,
  input  logic [PA_BITS-1:0]    memData,
  output logic                  entryValid,
  output logic [PA_BITS-1:0]    memAddr,
  output logic [FRAME_BITS-1:0] resultPpn,
  output logic                  resultWritable,
  output logic                  resultUser,
  output logic                  fault,
  output logic                  faultLevel
);
  localparam int PAD_BITS = PA_BITS - LEVEL_BITS - ENTRY_SHIFT;

  logic [VPN_BITS-1:0]   vpnQ;
  logic [PA_BITS-1:0]    baseQ;
  logic [FRAME_BITS-1:0] leafFrameQ;
  logic [PA_BITS-1:0]    dirOffset, pteOffset;
  logic                  unusedEntryBits;

  assign entryValid = memData[VALID_BIT];
  assign unusedEntryBits = ^{memData[OFFSET_BITS-1:USER_BIT+1], strobes.issuePte};

  assign dirOffset = {{PAD_BITS{1'b0}}, vpnQ[VPN_BITS-1 -: LEVEL_BITS], {ENTRY_SHIFT{1'b0}}};
  assign pteOffset = {{PAD_BITS{1'b0}}, vpnQ[LEVEL_BITS-1:0], {ENTRY_SHIFT{1'b0}}};

  always_comb begin
    if (strobes.issueDir) memAddr = baseQ + dirOffset;
    else                  memAddr = {leafFrameQ, {OFFSET_BITS{1'b0}}} + pteOffset;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vpnQ           <= '0;
      baseQ          <= '0;
      leafFrameQ     <= '0;
      resultPpn      <= '0;
      resultWritable <= 1'b0;
      resultUser     <= 1'b0;
      fault          <= 1'b0;
      faultLevel     <= 1'b0;
    end else begin
      if (strobes.latchReq) begin
        vpnQ       <= walkVpn;
        baseQ      <= tableBase;
        fault      <= 1'b0;
        faultLevel <= 1'b0;
      end
      if (strobes.takeDir) begin
        if (entryValid) leafFrameQ <= memData[PA_BITS-1:OFFSET_BITS];
        else begin
          fault      <= 1'b1;
          faultLevel <= 1'b0;
        end
      end
      if (strobes.takePte) begin
        resultPpn      <= memData[PA_BITS-1:OFFSET_BITS];
        resultWritable <= memData[WRITE_BIT];
        resultUser     <= memData[USER_BIT];
        fault          <= ~entryValid;
        faultLevel     <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/page_walker.sv
module page_walker
  import ptw_pkg::*;
#(
  parameter int PA_BITS     = PA_BITS_DEF,
  parameter int OFFSET_BITS = OFFSET_BITS_DEF,
  parameter int LEVEL_BITS  = LEVEL_BITS_DEF,
  localparam int VPN_BITS   = 2 * LEVEL_BITS,
  localparam int FRAME_BITS = PA_BITS - OFFSET_BITS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  walkReq,
  input  logic [VPN_BITS-1:0]   walkVpn,
  input  logic [PA_BITS-1:0]    tableBase,
  output logic                  busy,
  output logic                  memReq,
  output logic [PA_BITS-1:0]    memAddr,
  input  logic                  memValid,
  input  logic [PA_BITS-1:0]    memData,
  output logic                  done,
  output logic [FRAME_BITS-1:0] resultPpn,
  output logic                  resultWritable,
  output logic                  resultUser,
  output logic                  fault,
  output logic                  faultLevel
);
  walkStrobes_t strobes;
  logic         entryValid;

  ptw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .walkReq(walkReq), .memValid(memValid),
    .entryValid(entryValid), .strobes(strobes), .busy(busy),
    .memReq(memReq), .done(done)
  );

  ptw_datapath #(
    .PA_BITS(PA_BITS), .OFFSET_BITS(OFFSET_BITS), .LEVEL_BITS(LEVEL_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .walkVpn(walkVpn),
    .tableBase(tableBase), .memData(memData), .entryValid(entryValid),
    .memAddr(memAddr), .resultPpn(resultPpn), .resultWritable(resultWritable),
    .resultUser(resultUser), .fault(fault), .faultLevel(faultLevel)
  );
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker (
  input logic clk,
  input logic rstN,
  input logic walkReq,
  input logic busy,
  input logic memReq,
  input logic memValid,
  input logic done
);
  a_r9_req_pulse: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);
  a_r9_req_in_walk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r2_accept: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && walkReq) |=> (busy && memReq));
  a_r7_release: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  a_r8_stray_valid: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !walkReq && memValid) |=> (!busy && !done));
endmodule

bind page_walker ptw_checker u_ptwChecker (
  .clk(clk), .rstN(rstN), .walkReq(walkReq), .busy(busy),
  .memReq(memReq), .memValid(memValid), .done(done)
);

// File: tb/page_walker_bench.sv
module page_walker_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        walkReq = 1'b0;
  logic [19:0] walkVpn = '0;
  logic [31:0] tableBase = '0;
  logic        busy, memReq, done;
  logic [31:0] memAddr;
  logic        memValid = 1'b0;
  logic [31:0] memData = '0;
  logic [19:0] resultPpn;
  logic        resultWritable, resultUser, fault, faultLevel;

  int compared = 0;
  int mismatched = 0;
  int lat = 1;
  bit strayReq = 0;
  bit finished = 0;
  logic [31:0] memImg [int unsigned];

  always #(CLK_PERIOD/2) clk = ~clk;

  page_walker u_page_walker (
    .clk(clk), .rstN(rstN), .walkReq(walkReq), .walkVpn(walkVpn),
    .tableBase(tableBase), .busy(busy), .memReq(memReq), .memAddr(memAddr),
    .memValid(memValid), .memData(memData), .done(done), .resultPpn(resultPpn),
    .resultWritable(resultWritable), .resultUser(resultUser), .fault(fault),
    .faultLevel(faultLevel)
  );

  function automatic logic [31:0] peek(input logic [31:0] a);
    if (memImg.exists(a)) return memImg[a];
    return 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // memory responder: countdown from each observed request
  int pendCnt = 0;
  logic [31:0] pendAddr = '0;
  initial forever begin
    @(posedge clk); #1;
    memValid = 1'b0;
    if (strayReq) begin
      memValid = 1'b1;
      memData  = 32'hFFFF_FFFF;
    end
    if (pendCnt > 0) begin
      pendCnt--;
      if (pendCnt == 0) begin
        memValid = 1'b1;
        memData  = peek(pendAddr);
      end
    end
    if (memReq) begin
      pendAddr = memAddr;
      pendCnt  = lat;
    end
  end

  // reference model, compared every cycle
  bit mBusy = 0, mDoneNow = 0, mReqNow = 0, mAwait = 0;
  int mLevel = 0;
  logic [31:0] mAddr = '0;
  logic [19:0] mVpn = '0;
  logic [19:0] ePpn = '0;
  bit eFault = 0, eLevel = 0, eWr = 0, eUser = 0;

  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit nDone, nReq;
      logic [31:0] ent;
      chk(busy == mBusy, "R7 busy", 32'(busy), 32'(mBusy));
      chk(done == mDoneNow, "R10 done", 32'(done), 32'(mDoneNow));
      chk(memReq == mReqNow, "R9 memReq", 32'(memReq), 32'(mReqNow));
      if (mReqNow && memReq)
        chk(memAddr == mAddr, (mLevel == 0) ? "R2 dirAddr" : "R3 pteAddr", memAddr, mAddr);
      if (mDoneNow && done) begin
        chk(fault == eFault, eLevel ? "R6 fault" : "R5 fault", 32'(fault), 32'(eFault));
        if (eFault) chk(faultLevel == eLevel, "R5/R6 faultLevel", 32'(faultLevel), 32'(eLevel));
        else begin
          chk(resultPpn == ePpn, "R4 ppn", 32'(resultPpn), 32'(ePpn));
          chk(resultWritable == eWr, "R4 writable", 32'(resultWritable), 32'(eWr));
          chk(resultUser == eUser, "R4 user", 32'(resultUser), 32'(eUser));
        end
      end
      nDone = 0; nReq = 0;
      if (mDoneNow) mBusy = 0;
      else if (!mBusy && walkReq) begin
        mBusy = 1; mVpn = walkVpn; mLevel = 0;
        mAddr = tableBase + 32'(mVpn[19:10]) * 4;
        nReq = 1;
      end
      if (mAwait && memValid) begin
        mAwait = 0;
        ent = peek(mAddr);
        if (mLevel == 0) begin
          if (!ent[0]) begin
            nDone = 1; eFault = 1; eLevel = 0;
          end else begin
            mAddr = {ent[31:12], 12'h000} + 32'(mVpn[9:0]) * 4;
            mLevel = 1; nReq = 1;
          end
        end else begin
          nDone = 1; eFault = !ent[0]; eLevel = 1;
          ePpn = ent[31:12]; eWr = ent[1]; eUser = ent[2];
        end
      end
      if (mReqNow) mAwait = 1;
      mDoneNow = nDone; mReqNow = nReq;
    end
  end

  task automatic startWalk(input logic [19:0] v, input logic [31:0] b);
    @(posedge clk); #1;
    walkReq = 1'b1; walkVpn = v; tableBase = b;
    @(posedge clk); #1;
    walkReq = 1'b0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (done) break;
    end
    @(posedge clk); #1;
  endtask

  task automatic walk(input logic [19:0] v, input logic [31:0] b, input int l);
    lat = l;
    startWalk(v, b);
    waitDone();
  endtask

  initial begin
    memImg[32'h0001_0004] = 32'h0002_0001;
    memImg[32'h0001_0008] = 32'h0009_9000;
    memImg[32'h0001_0FFC] = 32'h0003_0001;
    memImg[32'h0002_000C] = 32'hABCD_E007;
    memImg[32'h0002_0FFC] = 32'h1234_5003;
    memImg[32'h0002_0014] = 32'h5555_5006;
    memImg[32'h0003_0000] = 32'h0000_1001;
    memImg[32'h0004_0004] = 32'h0005_0001;
    memImg[32'h0005_000C] = 32'h7777_7005;

    repeat (3) @(posedge clk);
    #1;
    chk(!busy && !done && !memReq && !fault, "R1 reset", {busy, done, memReq, fault}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !memReq, "R1 after release", {busy, done, memReq}, 32'h0);

    walk({10'd1, 10'd3}, 32'h0001_0000, 1);      // R4 full permissions
    walk({10'd1, 10'd3}, 32'h0001_0000, 4);      // R9 longer latency
    walk({10'd1, 10'h3FF}, 32'h0001_0000, 2);    // R3 top slot of leaf
    walk({10'd2, 10'd7}, 32'h0001_0000, 1);      // R5 directory fault
    walk({10'd1, 10'd5}, 32'h0001_0000, 3);      // R6 leaf fault
    walk({10'h3FF, 10'd0}, 32'h0001_0000, 1);    // R2 top directory slot
    walk({10'd1, 10'd3}, 32'h0004_0000, 2);      // R2 other base

    // R7: request lines hammered while busy
    lat = 5;
    startWalk({10'd1, 10'd3}, 32'h0001_0000);
    @(posedge clk); #1;
    walkReq = 1'b1; walkVpn = {10'd2, 10'd0}; tableBase = 32'h0004_0000;
    repeat (3) @(posedge clk);
    #1;
    walkReq = 1'b0;
    waitDone();

    // R8: stray response while idle
    @(posedge clk); #1;
    strayReq = 1'b1;
    @(posedge clk); #1;
    strayReq = 1'b0;
    repeat (2) @(negedge clk);
    chk(!busy && !done, "R8 stray valid", {busy, done}, 32'h0);

    repeat (3) @(posedge clk);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule